// File: doc/BRIEF.md
# Panel grey-scale frame-modulation generator

This block turns a 4-bit colour code for each pixel into an on/off drive level for a monochrome flat panel. Such a panel can only light a dot or leave it dark, so intermediate shades come from lighting the dot in only some of the frames of a short repeating cycle. Each code has its own fraction of lit frames. The codes fall into groups that repeat every 3, 4, 5, 6 or 7 frames.

Any code from 7 to 15 can be switched from plain frame modulation to hatching. A hatched code keeps the same lit fraction, but pixels on the odd checkerboard squares run half a cycle out of step with pixels on the even squares. The result is a fine checker texture instead of a uniform flicker. When the converter is disabled, the code is passed straight through so that a colour panel path can use it.

The output is combinational from the pixel inputs and the frame-phase registers. A pixel therefore sees its drive level in the same cycle it is presented.

Top module: `panel_tone_mod`

## Requirements
- R1: With `conv_en` low, `pix_out` equals `pix_code` in every cycle.
- R2: With `conv_en` high, `pix_out[3:1]` is zero and `pix_out[0]` carries the drive level (1 means lit).
- R3: With `conv_en` high, code 0 is never lit and code 3 is always lit, whatever the frame, position or select bits.
- R4: The phase P_L of an L-frame cycle is the number of `frame_start` pulses since reset, modulo L. A non-hatched code with length L and numerator K is lit when P_L < K. Codes 1 and 2 use L=3 with K=1 and K=2.
- R5: Codes 4, 5 and 6 use L=4 with K=1, 2 and 3.
- R6: With `grad_en` high, non-hatched codes use the following lengths and numerators. Codes 7, 8, 9 and 10 use L=5 with K=1, 2, 3 and 4. Codes 11 and 12 use L=6 with K=1 and 5. Codes 13, 14 and 15 use L=7 with K=2, 3 and 4.
- R7: With `grad_en` low, any non-hatched code from 7 to 15 is always lit.
- R8: Bit k of `hatch_sel` (k = 0..7) makes code 8+k hatched, and `hatch7_sel` makes code 7 hatched. A hatched code uses the L and K of R6 whatever the value of `grad_en`. It is lit when ((P_L + s*floor(L/2)) mod L) < K, where s = `x_odd` XOR `y_odd`.
- R9: The frame phases change only on a clock edge where `frame_start` is high. With `frame_start` low and the inputs held, the output does not change.
- R10: A synchronous `rst` returns every frame phase to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_start | input | 1 | One-cycle strobe that advances all frame phases |
| conv_en | input | 1 | Enables the converter; when low the code passes through |
| grad_en | input | 1 | Enables the 5/6/7-frame tones for codes 7 to 15 |
| hatch7_sel | input | 1 | Hatching select for code 7 |
| hatch_sel | input | 8 | Hatching select for codes 8 to 15, bit k for code 8+k |
| pix_code | input | 4 | Colour code of the current pixel |
| x_odd | input | 1 | Column parity of the current pixel |
| y_odd | input | 1 | Row parity of the current pixel |
| pix_out | output | 4 | Pass-through code, or the drive level in bit 0 |

## Verification
The bench steps through whole modulation cycles and checks every code at all four parity combinations against a frame count it keeps itself. A design with a counter that wraps one frame late, or a swapped numerator, shows up as a wrong level in a specific frame. Hatching is checked one select bit at a time, with the other bits cleared. A decoder that maps a bit to the wrong code, or applies the shift on the wrong parity, then lights the wrong checker square. Further checks confirm that plain modulation ignores the parity inputs and that hatching overrides a cleared `grad_en`. The bench also holds `frame_start` low for several cycles and applies a reset in the middle of a cycle. A design whose phases drift without a strobe, or that only partly clears them, gives the wrong level in the following frame.

// File: rtl/panel_tone_mod.sv
module panel_tone_mod #(
  parameter int CODE_W  = 4,
  parameter int CNT_W   = 3,
  parameter int MIN_LEN = 3,
  parameter int MAX_LEN = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              conv_en,
  input  logic              grad_en,
  input  logic              hatch7_sel,
  input  logic [7:0]        hatch_sel,
  input  logic [CODE_W-1:0] pix_code,
  input  logic              x_odd,
  input  logic              y_odd,
  output logic [CODE_W-1:0] pix_out
);

  localparam int SUM_W = CNT_W + 1;

  logic [CNT_W-1:0] phase [0:MAX_LEN];

  for (genvar n = 0; n <= MAX_LEN; n++) begin : g_len
    if (n < MIN_LEN) begin : g_unused
      assign phase[n] = '0;
    end else begin : g_ctr
      logic [CNT_W-1:0] c;
      always_ff @(posedge clk) begin
        if (rst)
          c <= '0;
        else if (frame_start)
          c <= (c == CNT_W'(n - 1)) ? '0 : c + 1'b1;
      end
      assign phase[n] = c;
    end
  end

  logic [CNT_W-1:0] len, num, cur;
  logic             hatched, solid, lit;
  logic [SUM_W-1:0] shifted, idx;

  always_comb begin
    len = CNT_W'(3);
    num = '0;
    case (pix_code)
      4'd0:  begin len = 3'd3; num = 3'd0; end
      4'd1:  begin len = 3'd3; num = 3'd1; end
      4'd2:  begin len = 3'd3; num = 3'd2; end
      4'd3:  begin len = 3'd3; num = 3'd3; end
      4'd4:  begin len = 3'd4; num = 3'd1; end
      4'd5:  begin len = 3'd4; num = 3'd2; end
      4'd6:  begin len = 3'd4; num = 3'd3; end
      4'd7:  begin len = 3'd5; num = 3'd1; end
      4'd8:  begin len = 3'd5; num = 3'd2; end
      4'd9:  begin len = 3'd5; num = 3'd3; end
      4'd10: begin len = 3'd5; num = 3'd4; end
      4'd11: begin len = 3'd6; num = 3'd1; end
      4'd12: begin len = 3'd6; num = 3'd5; end
      4'd13: begin len = 3'd7; num = 3'd2; end
      4'd14: begin len = 3'd7; num = 3'd3; end
      default: begin len = 3'd7; num = 3'd4; end
    endcase
  end

  always_comb begin
    hatched = 1'b0;
    if (pix_code == 4'd7)
      hatched = hatch7_sel;
    else if (pix_code[3])
      hatched = hatch_sel[pix_code[2:0]];
  end

  assign cur     = phase[len];
  assign shifted = {1'b0, cur} + ((hatched && (x_odd ^ y_odd)) ? SUM_W'(len >> 1) : '0);
  assign idx     = (shifted >= SUM_W'(len)) ? shifted - SUM_W'(len) : shifted;
  assign solid   = (pix_code >= 4'd7) && !grad_en && !hatched;
  assign lit     = solid || (idx < SUM_W'(num));
  assign pix_out = conv_en ? {{(CODE_W-1){1'b0}}, lit} : pix_code;

endmodule

// File: rtl/panel_tone_mod_chk.sv
module panel_tone_mod_chk (
  input logic       clk,
  input logic       rst,
  input logic       frame_start,
  input logic       conv_en,
  input logic       grad_en,
  input logic       hatch7_sel,
  input logic [7:0] hatch_sel,
  input logic [3:0] pix_code,
  input logic       x_odd,
  input logic       y_odd,
  input logic [3:0] pix_out
);

  assert_bypass_R1: assert property (@(posedge clk) disable iff (rst)
    !conv_en |-> pix_out == pix_code);

  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
    conv_en |-> pix_out[3:1] == 3'b000);

  assert_code0_dark_R3: assert property (@(posedge clk) disable iff (rst)
    (conv_en && pix_code == 4'd0) |-> pix_out == 4'd0);

  assert_code3_lit_R3: assert property (@(posedge clk) disable iff (rst)
    (conv_en && pix_code == 4'd3) |-> pix_out == 4'd1);

  assert_grad_off_solid_R7: assert property (@(posedge clk) disable iff (rst)
    (conv_en && !grad_en && pix_code == 4'd11 && !hatch_sel[3]) |-> pix_out == 4'd1);

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(frame_start) && !$past(rst) && $stable(pix_code) && $stable(conv_en) &&
     $stable(grad_en) && $stable(hatch_sel) && $stable(hatch7_sel) &&
     $stable(x_odd) && $stable(y_odd)) |-> $stable(pix_out));

endmodule

bind panel_tone_mod panel_tone_mod_chk u_chk (
  .clk(clk), .rst(rst), .frame_start(frame_start), .conv_en(conv_en),
  .grad_en(grad_en), .hatch7_sel(hatch7_sel), .hatch_sel(hatch_sel),
  .pix_code(pix_code), .x_odd(x_odd), .y_odd(y_odd), .pix_out(pix_out)
);

// File: tb/panel_tone_mod_bench.sv
`timescale 1ns/1ps
module panel_tone_mod_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_start = 1'b0;
  logic       conv_en = 1'b0;
  logic       grad_en = 1'b0;
  logic       hatch7_sel = 1'b0;
  logic [7:0] hatch_sel = 8'h00;
  logic [3:0] pix_code = 4'd0;
  logic       x_odd = 1'b0;
  logic       y_odd = 1'b0;
  logic [3:0] pix_out;

  int vectors = 0;
  int errors  = 0;
  int nf      = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  panel_tone_mod u_panel_tone_mod (
    .clk(clk), .rst(rst), .frame_start(frame_start), .conv_en(conv_en),
    .grad_en(grad_en), .hatch7_sel(hatch7_sel), .hatch_sel(hatch_sel),
    .pix_code(pix_code), .x_odd(x_odd), .y_odd(y_odd), .pix_out(pix_out)
  );

  function automatic logic [3:0] model(input int code, input int f);
    int L, K, ph;
    bit h;
    if (!conv_en) return 4'(code);
    case (code)
      0: begin L = 3; K = 0; end   1: begin L = 3; K = 1; end
      2: begin L = 3; K = 2; end   3: begin L = 3; K = 3; end
      4: begin L = 4; K = 1; end   5: begin L = 4; K = 2; end
      6: begin L = 4; K = 3; end   7: begin L = 5; K = 1; end
      8: begin L = 5; K = 2; end   9: begin L = 5; K = 3; end
      10: begin L = 5; K = 4; end  11: begin L = 6; K = 1; end
      12: begin L = 6; K = 5; end  13: begin L = 7; K = 2; end
      14: begin L = 7; K = 3; end  default: begin L = 7; K = 4; end
    endcase
    h = (code == 7) ? hatch7_sel : (code >= 8) ? hatch_sel[code-8] : 1'b0;
    if (code >= 7 && !grad_en && !h) return 4'd1;
    ph = f % L;
    if (h && (x_odd ^ y_odd)) ph = (ph + L / 2) % L;
    return (ph < K) ? 4'd1 : 4'd0;
  endfunction

  task automatic check(input string req, input logic [3:0] exp);
    vectors++;
    if (pix_out !== exp) begin
      errors++;
      $display("FAIL %s code=%0d frame=%0d x=%0b y=%0b got=%0d exp=%0d",
               req, pix_code, nf, x_odd, y_odd, pix_out, exp);
    end
  endtask

  task automatic probe_all(input string req, input int lo, input int hi);
    @(negedge clk);
    #0.2;
    for (int c = lo; c <= hi; c++) begin
      for (int p = 0; p < 4; p++) begin
        pix_code = 4'(c);
        x_odd = p[0];
        y_odd = p[1];
        #0.05;
        check(req, model(c, nf));
      end
    end
  endtask

  task automatic next_frame();
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    nf++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    nf = 0;
  endtask

  task automatic t_reset_state();
    conv_en = 1'b1; grad_en = 1'b1; hatch_sel = 8'h00; hatch7_sel = 1'b0;
    probe_all("R10", 0, 15);
  endtask

  task automatic t_bypass();
    conv_en = 1'b0;
    for (int f = 0; f < 3; f++) begin
      probe_all("R1", 0, 15);
      next_frame();
    end
    conv_en = 1'b1;
  endtask

  task automatic t_grey_cycles();
    conv_en = 1'b1; grad_en = 1'b1; hatch_sel = 8'h00; hatch7_sel = 1'b0;
    for (int f = 0; f < 90; f++) begin
      probe_all("R4", 1, 2);
      probe_all("R5", 4, 6);
      probe_all("R6", 7, 15);
      probe_all("R3", 0, 0);
      probe_all("R3", 3, 3);
      probe_all("R2", 0, 15);
      next_frame();
    end
  endtask

  task automatic t_grad_off();
    grad_en = 1'b0; hatch_sel = 8'h00; hatch7_sel = 1'b0;
    for (int f = 0; f < 8; f++) begin
      probe_all("R7", 7, 15);
      next_frame();
    end
    grad_en = 1'b1;
  endtask

  task automatic t_hatch();
    for (int b = 0; b < 9; b++) begin
      hatch_sel  = (b < 8) ? 8'(1 << b) : 8'h00;
      hatch7_sel = (b == 8);
      for (int g = 0; g < 2; g++) begin
        grad_en = g[0];
        for (int f = 0; f < 8; f++) begin
          probe_all("R8", 7, 15);
          next_frame();
        end
      end
    end
    hatch_sel = 8'h00; hatch7_sel = 1'b0; grad_en = 1'b1;
  endtask

  task automatic t_hold();
    for (int i = 0; i < 12; i++) begin
      probe_all("R9", 1, 15);
    end
  endtask

  task automatic t_mid_reset();
    repeat (4) next_frame();
    do_reset();
    probe_all("R10", 0, 15);
    next_frame();
    probe_all("R10", 0, 15);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    t_reset_state();
    t_bypass();
    t_grey_cycles();
    t_grad_off();
    t_hatch();
    t_hold();
    t_mid_reset();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule